// File: doc/BRIEF.md
# Plane Degamma Table with Indexed Host Port

This block holds the degamma lookup table of one display plane. A host programs it through two registers. The index register selects an entry and can switch on auto-increment. Each access to the data register then writes or reads the selected entry. With auto-increment on, the index moves to the next entry, so a full table can be streamed into consecutive data-register writes. The pixel path fetches entries through a separate registered read port.

A parameter chooses between two variants. The high-precision variant holds 128 nominal entries of 24 bits. The standard variant holds 32 nominal entries of 16 bits. Both variants have three extended entries directly after the nominal range. These hold the clamp values used for inputs above 1.0, and they are one bit wider than a nominal entry so that they can hold exactly 1.0. Nominal entries take a 32-bit host value and reduce it to entry width by rounding half up. Extended entries keep the written bits as they are. At reset the table holds a linear identity ramp.

Top module: `degamma_lut`

## Requirements
- R1: An index-register write loads the entry pointer from bits [7:0] and the auto-increment enable from bit 10. Reading the index register returns the pointer in bits [7:0] and the enable in bit 10, with all other bits zero.
- R2: Writing zero to the index register clears auto-increment and returns the pointer to entry 0. A later data access then leaves the pointer at 0.
- R3: With auto-increment on, a data-register write stores the entry at the pointer and advances the pointer by one.
- R4: With auto-increment off, a data-register read or write leaves the pointer unchanged.
- R5: A write to a nominal entry (index below the nominal count) stores the 32-bit value reduced to the entry width W. The reduction adds 1<<(31−W), shifts right by 32−W and saturates at 2^W−1.
- R6: A write to an extended entry (the three indices after the nominal range) stores the low W+1 bits of the written value without rounding.
- R7: The pointer advances up to one past the last extended entry and stays there; it never wraps. Data writes at or beyond that position change no entry, and data reads there return zero.
- R8: A data-register read returns the entry at the pointer on hostRdata, with hostRdValid high, one cycle after the request. With auto-increment on, the read also advances the pointer.
- R9: After reset, nominal entry i holds i·(2^W−1)/(N−1), where N is the nominal count. Each extended entry holds 1<<W. The pointer and the auto-increment enable are both zero.
- R10: A pixel read presents the entry on pixData with pixValid one cycle after pixEn, and out-of-range addresses return zero. A pixel read and a host write to the same entry in the same cycle return the entry's old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostReq | input | 1 | Host register access this cycle |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostSel | input | 1 | 0 = index register, 1 = data register |
| hostWdata | input | 32 | Host write value |
| hostRdata | output | 32 | Host read value |
| hostRdValid | output | 1 | hostRdata holds the result of the previous cycle's read |
| pixEn | input | 1 | Pixel-path fetch request |
| pixAddr | input | 8 | Pixel-path entry address |
| pixData | output | W+1 | Fetched entry (25 bits high-precision, 17 bits standard) |
| pixValid | output | 1 | pixData holds the result of the previous cycle's fetch |

## Verification
The bound checker checks the pointer rules on every cycle. With auto-increment on, the pointer advances by one. With it off, the pointer holds. It saturates past the last extended entry, and a zero written to the index register clears the pointer. The checker also checks the one-cycle valid timing of both read paths.

Only the bench's scenarios can show what the table actually contains: the reset identity ramp, rounding and saturation on nominal entries, raw storage in extended entries, and writes beyond the end that must be ignored. The bench also covers the old-value result when a pixel fetch and a host write hit the same entry.

// File: rtl/degamma_pkg.sv
package degamma_pkg;
  localparam int IDX_W    = 8;
  localparam int AUTO_BIT = 10;
  localparam int EXT_CNT  = 3;

  typedef struct packed {
    logic idxWr;
    logic idxRd;
    logic datWr;
    logic datRd;
    logic advance;
  } strobe_t;
endpackage

// File: rtl/degamma_ctrl.sv
module degamma_ctrl
  import degamma_pkg::*;
#(
  parameter int DEPTH = 131
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostReq,
  input  logic             hostWrite,
  input  logic             hostSel,
  input  logic [31:0]      hostWdata,
  output strobe_t          strb,
  output logic [IDX_W-1:0] ptr,
  output logic             autoInc
);
  localparam logic [IDX_W-1:0] DEPTH_I = IDX_W'(DEPTH);

  logic inRange;

  always_comb begin
    inRange      = ptr < DEPTH_I;
    strb.idxWr   = hostReq &&  hostWrite && !hostSel;
    strb.idxRd   = hostReq && !hostWrite && !hostSel;
    strb.datWr   = hostReq &&  hostWrite &&  hostSel && inRange;
    strb.datRd   = hostReq && !hostWrite &&  hostSel;
    strb.advance = hostReq && hostSel && autoInc && inRange;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr     <= '0;
      autoInc <= 1'b0;
    end else if (strb.idxWr) begin
      ptr     <= hostWdata[IDX_W-1:0];
      autoInc <= hostWdata[AUTO_BIT];
    end else if (strb.advance) begin
      ptr <= ptr + 1'b1;
    end
  end
endmodule

// File: rtl/degamma_store.sv
module degamma_store
  import degamma_pkg::*;
#(
  parameter int NOM = 128,
  parameter int WID = 24,
  localparam int EW    = WID + 1,
  localparam int DEPTH = NOM + EXT_CNT,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [IDX_W-1:0] ptr,
  input  logic             autoInc,
  input  logic [31:0]      hostWdata,
  output logic [31:0]      hostRdata,
  output logic             hostRdValid,
  input  logic             pixEn,
  input  logic [IDX_W-1:0] pixAddr,
  output logic [EW-1:0]    pixData,
  output logic             pixValid
);
  localparam logic [IDX_W-1:0] DEPTH_I = IDX_W'(DEPTH);
  localparam logic [IDX_W-1:0] NOM_I   = IDX_W'(NOM);
  localparam logic [32:0]      MAXV    = (33'd1 << WID) - 33'd1;

  logic [EW-1:0] table_q [DEPTH];
  logic [EW-1:0] storeVal;

  function automatic logic [EW-1:0] rampEntry(input int i);
    logic [63:0] num;
    if (i < NOM) begin
      num = 64'(i) * ((64'd1 << WID) - 64'd1);
      return EW'(num / 64'(NOM - 1));
    end
    return EW'(64'd1 << WID);
  endfunction

  function automatic logic [EW-1:0] roundIn(input logic [31:0] w);
    logic [32:0] sum;
    logic [32:0] sh;
    sum = {1'b0, w} + (33'd1 << (31 - WID));
    sh  = sum >> (32 - WID);
    return (sh > MAXV) ? EW'(MAXV) : EW'(sh);
  endfunction

  always_comb begin
    storeVal = (ptr < NOM_I) ? roundIn(hostWdata) : hostWdata[EW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) table_q[i] <= rampEntry(i);
    end else if (strb.datWr) begin
      table_q[AW'(ptr)] <= storeVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostRdata   <= '0;
      hostRdValid <= 1'b0;
    end else begin
      hostRdValid <= strb.idxRd || strb.datRd;
      if (strb.idxRd) begin
        hostRdata <= '0;
        hostRdata[IDX_W-1:0] <= ptr;
        hostRdata[AUTO_BIT]  <= autoInc;
      end else if (strb.datRd) begin
        hostRdata <= (ptr < DEPTH_I) ? 32'(table_q[AW'(ptr)]) : 32'd0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixData  <= '0;
      pixValid <= 1'b0;
    end else begin
      pixValid <= pixEn;
      if (pixEn) pixData <= (pixAddr < DEPTH_I) ? table_q[AW'(pixAddr)] : '0;
    end
  end
endmodule

// File: rtl/degamma_lut.sv
module degamma_lut
  import degamma_pkg::*;
#(
  parameter bit HIGH_PREC = 1'b1,
  localparam int NOM   = HIGH_PREC ? 128 : 32,
  localparam int WID   = HIGH_PREC ? 24 : 16,
  localparam int EW    = WID + 1,
  localparam int DEPTH = NOM + EXT_CNT
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostReq,
  input  logic             hostWrite,
  input  logic             hostSel,
  input  logic [31:0]      hostWdata,
  output logic [31:0]      hostRdata,
  output logic             hostRdValid,
  input  logic             pixEn,
  input  logic [IDX_W-1:0] pixAddr,
  output logic [EW-1:0]    pixData,
  output logic             pixValid
);
  strobe_t          strb;
  logic [IDX_W-1:0] ptr;
  logic             autoInc;

  degamma_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWrite(hostWrite),
    .hostSel(hostSel), .hostWdata(hostWdata), .strb(strb), .ptr(ptr),
    .autoInc(autoInc)
  );

  degamma_store #(.NOM(NOM), .WID(WID)) u_store (
    .clk(clk), .rstN(rstN), .strb(strb), .ptr(ptr), .autoInc(autoInc),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .hostRdValid(hostRdValid),
    .pixEn(pixEn), .pixAddr(pixAddr), .pixData(pixData), .pixValid(pixValid)
  );
endmodule

// File: rtl/degamma_lut_chk.sv
module degamma_lut_chk
  import degamma_pkg::*;
#(
  parameter int DEPTH = 131
) (
  input logic             clk,
  input logic             rstN,
  input logic             hostReq,
  input logic             hostWrite,
  input logic             hostSel,
  input logic [31:0]      hostWdata,
  input logic             hostRdValid,
  input logic             pixEn,
  input logic             pixValid,
  input logic [IDX_W-1:0] ptr,
  input logic             autoInc
);
  localparam logic [IDX_W-1:0] DEPTH_I = IDX_W'(DEPTH);

  p_advance_r3: assert property (@(posedge clk) disable iff (!rstN)
    hostReq && hostSel && autoInc && ptr < DEPTH_I |=> ptr == IDX_W'($past(ptr) + 1'b1));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    hostReq && hostSel && !autoInc |=> $stable(ptr));

  p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rstN)
    hostReq && hostSel && ptr >= DEPTH_I |=> $stable(ptr));

  p_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    hostReq && hostWrite && !hostSel && hostWdata == 32'd0 |=> ptr == '0 && !autoInc);

  p_rd_valid_r8: assert property (@(posedge clk) disable iff (!rstN)
    hostReq && !hostWrite |=> hostRdValid);

  p_pix_valid_r10: assert property (@(posedge clk) disable iff (!rstN)
    pixEn |=> pixValid);
endmodule

bind degamma_lut degamma_lut_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWrite(hostWrite),
  .hostSel(hostSel), .hostWdata(hostWdata), .hostRdValid(hostRdValid),
  .pixEn(pixEn), .pixValid(pixValid), .ptr(ptr), .autoInc(autoInc)
);

// File: tb/degamma_lut_tb.sv
module degamma_lut_tb;
  localparam int NOM = 128, WID = 24, EW = 25, DEPTH = 131;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostReq = 1'b0, hostWrite = 1'b0, hostSel = 1'b0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic hostRdValid;
  logic pixEn = 1'b0;
  logic [7:0] pixAddr = '0;
  logic [EW-1:0] pixData;
  logic pixValid;

  int compared = 0, mismatched = 0;
  logic [31:0] hostQ[$];
  string hostTagQ[$];
  logic [31:0] pixQ[$];
  string pixTagQ[$];

  logic [EW-1:0] model [DEPTH];
  int mPtr = 0;
  bit mAuto = 1'b0;

  always #4 clk = ~clk;

  degamma_lut u_dut (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWrite(hostWrite),
    .hostSel(hostSel), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .hostRdValid(hostRdValid), .pixEn(pixEn), .pixAddr(pixAddr),
    .pixData(pixData), .pixValid(pixValid)
  );

  function automatic logic [EW-1:0] ramp(int i);
    if (i < NOM) return EW'((64'(i) * 64'(32'hFF_FFFF)) / 64'(NOM - 1));
    return EW'(32'h100_0000);
  endfunction

  function automatic logic [EW-1:0] rnd(logic [31:0] w);
    logic [32:0] v;
    v = ({1'b0, w} + 33'h80) >> 8;
    return (v > 33'hFF_FFFF) ? EW'(24'hFF_FFFF) : EW'(v);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expectations as results appear
  always @(negedge clk) begin
    if (rstN && hostRdValid) begin
      if (hostQ.size() == 0) check("host-unexpected", hostRdata, 32'hDEAD);
      else check(hostTagQ.pop_front(), hostRdata, hostQ.pop_front());
    end
    if (rstN && pixValid) begin
      if (pixQ.size() == 0) check("pix-unexpected", 32'(pixData), 32'hDEAD);
      else check(pixTagQ.pop_front(), 32'(pixData), pixQ.pop_front());
    end
  end

  task automatic idxWrite(logic [31:0] d);
    @(negedge clk);
    hostReq = 1; hostWrite = 1; hostSel = 0; hostWdata = d;
    mPtr = int'(d[7:0]); mAuto = d[10];
    @(negedge clk);
    hostReq = 0;
  endtask

  task automatic idxRead(string tag);
    @(negedge clk);
    hostReq = 1; hostWrite = 0; hostSel = 0;
    hostQ.push_back({21'd0, mAuto, 2'd0, 8'(mPtr)}); hostTagQ.push_back(tag);
    @(negedge clk);
    hostReq = 0;
  endtask

  task automatic modelWrite(logic [31:0] d);
    if (mPtr < DEPTH) begin
      model[mPtr] = (mPtr < NOM) ? rnd(d) : d[EW-1:0];
      if (mAuto) mPtr++;
    end
  endtask

  task automatic datWrite(logic [31:0] d);
    @(negedge clk);
    hostReq = 1; hostWrite = 1; hostSel = 1; hostWdata = d;
    modelWrite(d);
    @(negedge clk);
    hostReq = 0;
  endtask

  task automatic datRead(string tag);
    @(negedge clk);
    hostReq = 1; hostWrite = 0; hostSel = 1;
    hostQ.push_back(mPtr < DEPTH ? 32'(model[mPtr]) : 32'd0); hostTagQ.push_back(tag);
    if (mAuto && mPtr < DEPTH) mPtr++;
    @(negedge clk);
    hostReq = 0;
  endtask

  task automatic pixRead(int a, string tag);
    @(negedge clk);
    pixEn = 1; pixAddr = 8'(a);
    pixQ.push_back(a < DEPTH ? 32'(model[a]) : 32'd0); pixTagQ.push_back(tag);
    @(negedge clk);
    pixEn = 0;
  endtask

  task automatic collide(logic [31:0] d);
    @(negedge clk);
    pixEn = 1; pixAddr = 8'(mPtr);
    pixQ.push_back(32'(model[mPtr])); pixTagQ.push_back("R10 collision old value");
    hostReq = 1; hostWrite = 1; hostSel = 1; hostWdata = d;
    modelWrite(d);
    @(negedge clk);
    pixEn = 0; hostReq = 0;
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = ramp(i);
    repeat (3) @(negedge clk);
    rstN = 1;
    // R9 reset state
    idxRead("R9 reset index");
    pixRead(0, "R9 ramp 0");
    pixRead(1, "R9 ramp 1");
    pixRead(64, "R9 ramp 64");
    pixRead(127, "R9 ramp 127");
    pixRead(128, "R9 ext 128");
    pixRead(130, "R9 ext 130");
    pixRead(200, "R10 out of range");
    // R1 / R3 / R5
    idxWrite(32'h405);
    idxRead("R1 index readback");
    datWrite(32'h0000_00FF);
    datWrite(32'hFFFF_FFFF);
    datWrite(32'h0000_007F);
    idxRead("R3 advanced pointer");
    pixRead(5, "R5 round up");
    pixRead(6, "R5 saturate");
    pixRead(7, "R5 round down");
    // R4 / R8 without auto-increment
    idxWrite(32'h5);
    datRead("R8 data read");
    datRead("R4 pointer held");
    datWrite(32'h1234_5678);
    datRead("R5 rounding readback");
    idxRead("R4 pointer after access");
    // R2
    idxWrite(32'h0);
    idxRead("R2 cleared");
    datWrite(32'h0000_0100);
    idxRead("R2 no advance");
    pixRead(0, "R2 entry 0 written");
    // R6 / R7 extended entries and end of table
    idxWrite(32'h400 | 32'd127);
    datWrite(32'h00FF_FF00);
    datWrite(32'h0180_0000);
    datWrite(32'hFEFF_FFFF);
    datWrite(32'h0100_0000);
    datWrite(32'h0000_0055);
    datWrite(32'h0000_0066);
    idxRead("R7 pointer saturated");
    datRead("R7 read beyond end");
    idxRead("R7 no wrap");
    pixRead(127, "R5 last nominal");
    pixRead(128, "R6 ext raw");
    pixRead(129, "R6 ext truncated");
    pixRead(130, "R6 ext last");
    pixRead(0, "R7 ignored write");
    // R8 auto-increment reads
    idxWrite(32'h400 | 32'd5);
    datRead("R8 auto read 5");
    datRead("R8 auto read 6");
    datRead("R8 auto read 7");
    idxRead("R8 pointer after reads");
    // R10 collision
    idxWrite(32'h400 | 32'd10);
    collide(32'h00FF_FF00);
    pixRead(10, "R10 new value");
    repeat (4) @(negedge clk);
    check("R10 pixel queue drained", 32'(pixQ.size()), 32'd0);
    check("R8 host queue drained", 32'(hostQ.size()), 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule